// File: doc/BRIEF.md
# Status Register and Write-Permission Unit for a Serial Nonvolatile Memory

This block keeps the status byte of a serial memory slave and decides, every cycle, whether a write to the memory array and a write to the status byte are allowed. It sits between the command decoder and the array controller. The decoder sends it single-cycle event strobes: enable-write, disable-write, "status-write opcode recognised", "array-write opcode recognised", "status data byte complete", "output frame starts" and "chip select released". It also passes the level of the write-protect pin and the address the array controller is about to write.

The status byte holds a status-lock bit, three spare bits that can be written and read back, a two-bit block-protect field and the write-enable latch. The nonvolatile bits are loaded with a parameter value at reset. The block-protect field selects how much of the top of the address space is protected. The lock bit, together with the protect pin, can freeze the status byte. The write-enable latch gates both kinds of write. It is set by an explicit command and cleared by the disable command and by the release of chip select after any write-type command. Both permit outputs are decoded combinationally from the present state. The byte presented for status reads is captured once at the start of each output frame.

Top module: `wprot_status_unit`

## Requirements
- R1: The status byte reads as {lock, spare[2:0], bp[1:0], wel, 0}: bit 7 is the lock, bits 6:4 are spare, bits 3:2 are the protect field, bit 1 is the write-enable latch, and bit 0 always reads 0.
- R2: An enable strobe sets the write-enable latch. A disable strobe clears it, and it also wins when both strobes arrive in the same cycle.
- R3: A permitted status data load copies data bits 7:2 into lock, spare and protect, and ignores data bits 1:0. The write-enable latch is not changed by that load.
- R4: A chip-select release clears the write-enable latch if a status-write or array-write opcode was recognised since the previous release.
- R5: A chip-select release without such a recognised opcode (an aborted command) leaves the write-enable latch unchanged.
- R6: The protect field marks as protected: 00 no address; 01 the top quarter (the two top address bits both 1, 0x30000 to 0x3FFFF at 18 bits); 10 the top half (0x20000 to 0x3FFFF); 11 every address. A protected address never gets an array-write permit.
- R7: While the write-enable latch is 0, both permit outputs are 0.
- R8: The status-write permit is 1 exactly when the write-enable latch is 1 and not (lock is 1 and the protect pin is low).
- R9: A status data load that arrives while the status-write permit is 0 leaves the status byte unchanged.
- R10: The read byte output is updated only on a cycle with the frame-start strobe, with the value before that cycle's updates, and holds otherwise.
- R11: After reset, the nonvolatile bits take the parameter value with bits 1:0 forced to 0 (0x00 by default), the latch is 0, and both permits are 0.
- R12: The permits are combinational: a change of address or protect pin, or a latch change, shows on the permit outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wren_evt | input | 1 | Enable-write command recognised |
| wrdi_evt | input | 1 | Disable-write command recognised |
| wrsr_op_evt | input | 1 | Status-write opcode recognised |
| write_op_evt | input | 1 | Array-write opcode recognised |
| sr_load | input | 1 | Status-write data byte complete |
| sr_wdata | input | 8 | Status-write data byte |
| cs_rise | input | 1 | Chip select released |
| frame_start | input | 1 | Start of a status-read output frame |
| wp_pin | input | 1 | Protect pin level (0 = protect asserted) |
| wr_addr | input | ADDR_W | Address of the pending array write |
| status_byte | output | 8 | Byte presented for status reads |
| array_wr_ok | output | 1 | Array write at wr_addr permitted |
| sr_wr_ok | output | 1 | Status write permitted |

## Verification
On every cycle the assertions check the latch's response to its set, clear and release events, that an aborted selection keeps the latch, that a blocked status load freezes the nonvolatile bits, that the read byte holds between frames, and that the permits stay low when the latch is clear or everything is protected. Only the bench's scenarios can show the exact boundary addresses of each protect range, the bits that a data load ignores, the lock-and-pin combinations, and the values actually returned by successive status reads.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef struct packed {
    logic       lock;
    logic [2:0] spare;
    logic [1:0] bp;
  } nv_bits_t;

  localparam int NV_W = $bits(nv_bits_t);

  function automatic logic [7:0] pack_status(nv_bits_t nv, logic wel);
    return {nv.lock, nv.spare, nv.bp, wel, 1'b0};
  endfunction

endpackage

// File: rtl/wp_range_decode.sv
module wp_range_decode #(
  parameter int ADDR_W = 18
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_protected
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (bp)
      2'b00: in_protected = 1'b0;
      2'b01: in_protected = addr[TOP] & addr[TOP-1];
      2'b10: in_protected = addr[TOP];
      default: in_protected = 1'b1;
    endcase
  end

  always_comb begin
    if (bp == 2'b11) AST_ALL_COVERED: assert (in_protected); // R6
  end
endmodule

// File: rtl/wp_latch_ctrl.sv
module wp_latch_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wren_evt,
  input  logic wrdi_evt,
  input  logic wrsr_op_evt,
  input  logic write_op_evt,
  input  logic cs_rise,
  output logic wel
);
  logic wel_q, wel_d;
  logic pend_q, pend_d;
  logic wel_en, pend_en;

  always_comb begin
    pend_en = cs_rise | wrsr_op_evt | write_op_evt;
    pend_d  = pend_q;
    if (cs_rise)                         pend_d = 1'b0;
    else if (wrsr_op_evt | write_op_evt) pend_d = 1'b1;

    wel_en = wren_evt | wrdi_evt | (cs_rise & pend_q);
    wel_d  = wel_q;
    if (wrdi_evt || (cs_rise && pend_q)) wel_d = 1'b0;
    else if (wren_evt)                   wel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wel_en)  wel_q  <= wel_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign wel = wel_q;

  AST_WEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wren_evt && !wrdi_evt && !(cs_rise && pend_q) |=> wel); // R2
  AST_WEL_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wrdi_evt |=> !wel); // R2
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && pend_q |=> !wel); // R4
  AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && !pend_q && !wren_evt && !wrdi_evt |=> $stable(wel)); // R5
endmodule

// File: rtl/wp_status_store.sv
module wp_status_store
  import wp_pkg::*;
#(
  parameter logic [7:0] SR_RESET = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_load,
  input  logic       sr_ok,
  input  logic [7:0] sr_wdata,
  input  logic       wel,
  input  logic       frame_start,
  output nv_bits_t   nv,
  output logic [7:0] rd_byte
);
  localparam nv_bits_t NV_RST = SR_RESET[7:2];

  nv_bits_t   nv_q, nv_d;
  logic       nv_en;
  logic [7:0] rd_q, rd_d;
  logic [1:0] unused_lo;

  assign unused_lo = sr_wdata[1:0];

  always_comb begin
    nv_en = sr_load & sr_ok;
    nv_d  = sr_wdata[7:2];
    rd_d  = pack_status(nv_q, wel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q <= NV_RST;
      rd_q <= {SR_RESET[7:2], 2'b00};
    end else begin
      if (nv_en)       nv_q <= nv_d;
      if (frame_start) rd_q <= rd_d;
    end
  end

  assign nv      = nv_q;
  assign rd_byte = rd_q;

  AST_BLOCKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load && !sr_ok |=> $stable(nv_q)); // R9
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(rd_q)); // R10
  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !rd_q[0]); // R1
endmodule

// File: rtl/wprot_status_unit.sv
module wprot_status_unit
  import wp_pkg::*;
#(
  parameter int         ADDR_W   = 18,
  parameter logic [7:0] SR_RESET = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_evt,
  input  logic              wrdi_evt,
  input  logic              wrsr_op_evt,
  input  logic              write_op_evt,
  input  logic              sr_load,
  input  logic [7:0]        sr_wdata,
  input  logic              cs_rise,
  input  logic              frame_start,
  input  logic              wp_pin,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        status_byte,
  output logic              array_wr_ok,
  output logic              sr_wr_ok
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_ns = rst_sync_q[SYNC_N-1];

  logic     wel;
  nv_bits_t nv;
  logic     addr_prot;
  logic     sr_locked;

  wp_latch_ctrl u_latch (
    .clk          (clk),
    .rst_n        (rst_ns),
    .wren_evt     (wren_evt),
    .wrdi_evt     (wrdi_evt),
    .wrsr_op_evt  (wrsr_op_evt),
    .write_op_evt (write_op_evt),
    .cs_rise      (cs_rise),
    .wel          (wel)
  );

  wp_range_decode #(.ADDR_W(ADDR_W)) u_range (
    .bp           (nv.bp),
    .addr         (wr_addr),
    .in_protected (addr_prot)
  );

  always_comb begin
    sr_locked   = nv.lock & ~wp_pin;
    sr_wr_ok    = wel & ~sr_locked;
    array_wr_ok = wel & ~addr_prot;
  end

  wp_status_store #(.SR_RESET(SR_RESET)) u_store (
    .clk         (clk),
    .rst_n       (rst_ns),
    .sr_load     (sr_load),
    .sr_ok       (sr_wr_ok),
    .sr_wdata    (sr_wdata),
    .wel         (wel),
    .frame_start (frame_start),
    .nv          (nv),
    .rd_byte     (status_byte)
  );

  AST_NO_LATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_ns)
    !wel |-> !array_wr_ok && !sr_wr_ok); // R7
  AST_FULL_PROTECT: assert property (@(posedge clk) disable iff (!rst_ns)
    nv.bp == 2'b11 |-> !array_wr_ok); // R6
endmodule

// File: tb/wprot_status_unit_test.sv
`timescale 1ns/1ps
module wprot_status_unit_test;
  localparam int AW = 18;
  localparam int E_WREN = 0, E_WRDI = 1, E_WRSR = 2, E_WRITE = 3, E_CS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    evs = '0;
  logic          sr_load = 1'b0;
  logic [7:0]    sr_wdata = '0;
  logic          frame_start = 1'b0;
  logic          wp_pin = 1'b1;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    status_byte;
  logic          array_wr_ok, sr_wr_ok;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  wprot_status_unit #(.ADDR_W(AW), .SR_RESET(8'h00)) uut (
    .clk(clk), .rst_n(rst_n),
    .wren_evt(evs[E_WREN]), .wrdi_evt(evs[E_WRDI]),
    .wrsr_op_evt(evs[E_WRSR]), .write_op_evt(evs[E_WRITE]),
    .sr_load(sr_load), .sr_wdata(sr_wdata), .cs_rise(evs[E_CS]),
    .frame_start(frame_start), .wp_pin(wp_pin), .wr_addr(wr_addr),
    .status_byte(status_byte), .array_wr_ok(array_wr_ok), .sr_wr_ok(sr_wr_ok)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic strobe(int idx);
    @(negedge clk) evs[idx] = 1'b1;
    @(negedge clk) evs[idx] = 1'b0;
  endtask

  task automatic load_sr(logic [7:0] d);
    @(negedge clk) begin sr_load = 1'b1; sr_wdata = d; end
    @(negedge clk) sr_load = 1'b0;
  endtask

  task automatic rdsr(logic [7:0] exp, string tag);
    @(negedge clk) begin
      frame_start = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk) frame_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic perm(logic [AW-1:0] a, logic exp, string tag);
    @(negedge clk) wr_addr = a;
    #1 check(tag, {31'd0, array_wr_ok}, {31'd0, exp});
  endtask

  always @(posedge clk) begin
    if (frame_start) begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'd0, status_byte}, {24'd0, e});
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rdsr(8'h00, "R11 reset status");
    check("R11 reset array permit", {31'd0, array_wr_ok}, 32'd0);
    check("R11 reset status permit", {31'd0, sr_wr_ok}, 32'd0);

    // R12: permit follows the latch in the cycle right after the strobe edge
    @(negedge clk) evs[E_WREN] = 1'b1;
    @(negedge clk) evs[E_WREN] = 1'b0;
    #1 check("R12 permit follows latch", {31'd0, array_wr_ok}, 32'd1);
    rdsr(8'h02, "R2 wren sets latch");
    strobe(E_WRDI);
    rdsr(8'h00, "R2 wrdi clears latch");
    #1 check("R7 array permit with latch 0", {31'd0, array_wr_ok}, 32'd0);
    check("R7 status permit with latch 0", {31'd0, sr_wr_ok}, 32'd0);

    // R2: simultaneous enable and disable, disable wins
    @(negedge clk) begin evs[E_WREN] = 1'b1; evs[E_WRDI] = 1'b1; end
    @(negedge clk) begin evs[E_WREN] = 1'b0; evs[E_WRDI] = 1'b0; end
    rdsr(8'h00, "R2 disable wins");

    load_sr(8'h8C);
    rdsr(8'h00, "R9 load blocked with latch 0");

    strobe(E_WREN);
    strobe(E_WRSR);
    load_sr(8'hFF);
    rdsr(8'hFE, "R3 R1 load ignores bits 1:0, keeps latch");
    strobe(E_CS);
    rdsr(8'hFC, "R4 release after status write clears latch");

    strobe(E_WREN);
    perm(18'h00000, 1'b0, "R6 bp 11 protects address 0");
    @(negedge clk) wp_pin = 1'b0;
    #1 check("R8 locked with pin low", {31'd0, sr_wr_ok}, 32'd0);
    @(negedge clk) wp_pin = 1'b1;
    #1 check("R12 R8 pin high unlocks at once", {31'd0, sr_wr_ok}, 32'd1);

    @(negedge clk) wp_pin = 1'b0;
    load_sr(8'h00);
    rdsr(8'hFE, "R9 load blocked by lock");
    @(negedge clk) wp_pin = 1'b1;
    load_sr(8'h04);
    rdsr(8'h06, "R3 load with pin high");
    perm(18'h2FFFF, 1'b1, "R6 bp 01 below quarter");
    perm(18'h30000, 1'b0, "R6 bp 01 quarter start");
    load_sr(8'h08);
    rdsr(8'h0A, "R3 bp 10");
    perm(18'h1FFFF, 1'b1, "R6 bp 10 below half");
    perm(18'h20000, 1'b0, "R6 bp 10 half start");
    load_sr(8'h00);
    perm(18'h3FFFF, 1'b1, "R6 bp 00 top address");
    @(negedge clk) wp_pin = 1'b0;
    #1 check("R8 no lock, pin low permits", {31'd0, sr_wr_ok}, 32'd1);
    @(negedge clk) wp_pin = 1'b1;

    strobe(E_CS);
    rdsr(8'h02, "R5 aborted selection keeps latch");
    strobe(E_WRITE);
    strobe(E_CS);
    rdsr(8'h00, "R4 release after array write clears latch");

    strobe(E_WREN);
    rdsr(8'h02, "R10 frame captures latch");
    strobe(E_WRDI);
    repeat (2) @(negedge clk);
    check("R10 byte held without frame", {24'd0, status_byte}, 32'h02);
    rdsr(8'h00, "R10 next frame fresh");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule